// File: doc/BRIEF.md
# Mixed-Radix Frame Index Encoder

The block takes one frame of data bits and splits it into six indices, one for each signaling interval of a transmit frame. The valid bits are read as an unsigned integer. That integer is divided by a separate modulus for each of the first five intervals. Each remainder becomes that interval's index, and each quotient is carried forward to the next interval. The quotient left after the fifth division is the sixth index as it stands, with no modulo applied. The result is a mixed-radix decomposition, with the least significant digit first.

A frame is loaded with one handshake. That handshake carries the data word, the count of valid bits and the six moduli. The block then works through the intervals in time order. A single sequential shift-subtract divider is reused for each of the five divisions. Each index is presented with a valid/ready handshake and is held until it is taken. A new frame is refused until the sixth index has been taken. If the sixth index does not fit below the sixth modulus, an overflow flag is raised while that index is presented.

Top module: `mixed_radix_enc`

## Requirements
- R1: The frame value R0 is built from `data_i` bits 0 to `len_i`-1, with bit 0 least significant. Bits at positions `len_i` and above do not affect any index. `len_i` is used from 19 to 41.
- R2: For each interval i from 0 to 4, `idx_o` equals Ri mod Mi, and R(i+1) is the integer quotient of Ri divided by Mi. Mi is the 8-bit field `mods_i[8*i +: 8]` and holds a value from 2 to 128. Every index from 0 to 4 is below its modulus.
- R3: The index for interval 5 equals the low 8 bits of R5, with no modulo applied.
- R4: Indices are presented in the order `pos_o` = 0, 1, 2, 3, 4, 5. `last_o` is high only while `pos_o` = 5.
- R5: While `idx_valid_o` is high and `idx_ready_i` is low, `idx_o`, `pos_o`, `last_o` and `ovf_o` hold their values.
- R6: `start_ready_o` is low from the cycle after a frame is accepted until the index at position 5 is taken. An index is never presented while `start_ready_o` is high.
- R7: `ovf_o` is high while the position-5 index is presented if and only if R5 is greater than or equal to M5. `ovf_o` is low at every other time. The index is not saturated.
- R8: After reset, `start_ready_o` is high and `idx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Frame load request |
| start_ready_o | output | 1 | Block idle and able to accept a frame |
| data_i | input | 42 | Frame data bits, bit 0 first in time |
| len_i | input | 6 | Number of valid data bits |
| mods_i | input | 48 | Six 8-bit moduli, interval i in bits 8*i+7 to 8*i |
| idx_valid_o | output | 1 | Index valid |
| idx_ready_i | input | 1 | Downstream takes the index |
| idx_o | output | 8 | Index for the current interval |
| pos_o | output | 3 | Interval number of the current index |
| last_o | output | 1 | Current index is the final one of the frame |
| ovf_o | output | 1 | Final quotient does not fit below the final modulus |

## Verification
Assertions check several properties on every cycle:
- the divider remainder is below its divisor;
- each index from 0 to 4 is below the modulus of its interval;
- the output holds steady while it waits for ready;
- the overflow flag appears only with the final index;
- no index is presented while a frame could be accepted.

Only the bench scenarios can show the rest. These are the arithmetic values of the whole chain of divisions, the masking of the bits above the length, and the strict 0-to-5 order. They also cover the overflow decision against the final modulus and the refusal of a new frame in the middle of a frame. The bench checks all of these against a reference model on known vectors and random frames.

// File: rtl/mre_pkg.sv
package mre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_KICK,
    ST_WAIT,
    ST_OUT
  } mre_state_e;
endpackage

// File: rtl/mre_len_mask.sv
module mre_len_mask #(
  parameter int DATA_W = 42,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign data_o[k] = data_i[k] & (LEN_W'(k) < len_i);
  end
endmodule

// File: rtl/mre_divider.sv
module mre_divider #(
  parameter int DATA_W = 42,
  parameter int MOD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [MOD_W-1:0]  divisor_i,
  output logic              done_o,
  output logic [DATA_W-1:0] quo_o,
  output logic [MOD_W-1:0]  rem_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] quo_q;
  logic [MOD_W-1:0]  rem_q, dvs_q;
  logic [MOD_W:0]    trial, diff;
  logic              ge;
  logic              unused_diff_msb;

  assign trial = {rem_q, quo_q[DATA_W-1]};
  assign ge    = trial >= {1'b0, dvs_q};
  assign diff  = trial - {1'b0, dvs_q};
  assign unused_diff_msb = diff[MOD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= MOD_W'(1);
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(DATA_W);
        quo_q  <= dividend_i;
        rem_q  <= '0;
        dvs_q  <= divisor_i;
      end else if (busy_q) begin
        rem_q <= ge ? diff[MOD_W-1:0] : trial[MOD_W-1:0];
        quo_q <= {quo_q[DATA_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R2: remainder below the divisor at completion
  assert_rem_lt_div_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/mixed_radix_enc.sv
module mixed_radix_enc #(
  parameter int DATA_W  = 42,
  parameter int MOD_W   = 8,
  parameter int NUM_IDX = 6,
  parameter int LEN_W   = $clog2(DATA_W + 1),
  parameter int POS_W   = $clog2(NUM_IDX)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_valid_i,
  output logic                     start_ready_o,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [NUM_IDX*MOD_W-1:0] mods_i,
  output logic                     idx_valid_o,
  input  logic                     idx_ready_i,
  output logic [MOD_W-1:0]         idx_o,
  output logic [POS_W-1:0]         pos_o,
  output logic                     last_o,
  output logic                     ovf_o
);
  import mre_pkg::*;

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_IDX - 1);
  localparam logic [POS_W-1:0] POS_PRE  = POS_W'(NUM_IDX - 2);

  mre_state_e        st_q;
  logic [DATA_W-1:0] r_q, masked;
  logic [MOD_W-1:0]  mods_q [NUM_IDX];
  logic [POS_W-1:0]  pos_q;
  logic [MOD_W-1:0]  idx_q;
  logic              ovf_q;
  logic              div_done;
  logic [DATA_W-1:0] div_quo;
  logic [MOD_W-1:0]  div_rem;
  logic [MOD_W-1:0]  mod_cur, mod_last;

  mre_len_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_mask (
    .data_i (data_i),
    .len_i  (len_i),
    .data_o (masked)
  );

  assign mod_cur  = mods_q[pos_q];
  assign mod_last = mods_q[NUM_IDX-1];

  mre_divider #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (st_q == ST_KICK),
    .dividend_i (r_q),
    .divisor_i  (mod_cur),
    .done_o     (div_done),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      r_q   <= '0;
      pos_q <= '0;
      idx_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < NUM_IDX; i++) mods_q[i] <= MOD_W'(2);
    end else begin
      case (st_q)
        ST_IDLE: if (start_valid_i) begin
          r_q   <= masked;
          pos_q <= '0;
          ovf_q <= 1'b0;
          for (int i = 0; i < NUM_IDX; i++) mods_q[i] <= mods_i[i*MOD_W +: MOD_W];
          st_q  <= ST_KICK;
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          idx_q <= div_rem;
          r_q   <= div_quo;
          st_q  <= ST_OUT;
        end
        ST_OUT: if (idx_ready_i) begin
          if (pos_q == POS_LAST) begin
            ovf_q <= 1'b0;
            st_q  <= ST_IDLE;
          end else if (pos_q == POS_PRE) begin
            // final index: leftover quotient, no modulo
            pos_q <= pos_q + 1'b1;
            idx_q <= r_q[MOD_W-1:0];
            ovf_q <= r_q >= {{(DATA_W-MOD_W){1'b0}}, mod_last};
          end else begin
            pos_q <= pos_q + 1'b1;
            st_q  <= ST_KICK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready_o = (st_q == ST_IDLE);
  assign idx_valid_o   = (st_q == ST_OUT);
  assign idx_o         = idx_q;
  assign pos_o         = pos_q;
  assign last_o        = idx_valid_o && (pos_q == POS_LAST);
  assign ovf_o         = ovf_q;

  // R2: indices before the last are below their modulus
  assert_idx_lt_mod_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_o && pos_o != POS_LAST) |-> (idx_o < mod_cur));
  // R5: output held under backpressure
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_o && !idx_ready_i) |=>
      (idx_valid_o && $stable(idx_o) && $stable(pos_o) && $stable(ovf_o)));
  // R6: no output while a frame may be accepted
  assert_no_out_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o |-> !idx_valid_o);
  // R7: overflow only with the final index
  assert_ovf_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> last_o);
  // R4: a taken non-final index is followed by no output or the next position
  assert_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_o && idx_ready_i && !last_o) |=> (!idx_valid_o || pos_o == $past(pos_o) + 1'b1));
endmodule

// File: tb/mixed_radix_enc_tb.sv
module mixed_radix_enc_tb;
  localparam int DATA_W = 42;
  localparam int MOD_W  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_valid_i = 1'b0;
  logic start_ready_o;
  logic [DATA_W-1:0] data_i = '0;
  logic [5:0] len_i = '0;
  logic [47:0] mods_i = '0;
  logic idx_valid_o;
  logic idx_ready_i = 1'b0;
  logic [7:0] idx_o;
  logic [2:0] pos_o;
  logic last_o, ovf_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  mixed_radix_enc u_dut (
    .clk_i, .rst_ni, .start_valid_i, .start_ready_o, .data_i, .len_i, .mods_i,
    .idx_valid_o, .idx_ready_i, .idx_o, .pos_o, .last_o, .ovf_o
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  longint unsigned exp_idx [6];
  bit exp_ovf;

  function automatic void model(input longint unsigned d, input int len, input logic [47:0] m);
    longint unsigned r;
    longint unsigned mk;
    mk = (len >= 64) ? '1 : ((64'd1 << len) - 1);
    r = d & mk;
    for (int i = 0; i < 5; i++) begin
      exp_idx[i] = r % longint'(m[8*i +: 8]);
      r = r / longint'(m[8*i +: 8]);
    end
    exp_idx[5] = r & 64'hFF;
    exp_ovf = (r >= longint'(m[47:40]));
  endfunction

  task automatic run_frame(input longint unsigned d, input int len, input logic [47:0] m, input bit stall_ok);
    model(d, len, m);
    @(negedge clk_i);
    while (!start_ready_o) @(negedge clk_i);
    data_i = d[DATA_W-1:0];
    len_i = 6'(len);
    mods_i = m;
    start_valid_i = 1'b1;
    @(negedge clk_i);
    start_valid_i = 1'b0;
    data_i = '1;
    mods_i = '0;
    chk("R6 busy after accept", start_ready_o, 0);
    for (int i = 0; i < 6; i++) begin
      while (!idx_valid_o) @(negedge clk_i);
      if (i == 0) chk("R6 not ready mid-frame", start_ready_o, 0);
      if (stall_ok && ($urandom % 3 == 0)) begin
        logic [7:0] h = idx_o;
        @(negedge clk_i);
        @(negedge clk_i);
        chk("R5 hold valid", idx_valid_o, 1);
        chk("R5 hold idx", idx_o, h);
      end
      chk("R4 position", pos_o, i);
      chk("R4 last flag", last_o, (i == 5));
      if (i < 5) chk("R2 index", idx_o, exp_idx[i]);
      else chk("R3 final index", idx_o, exp_idx[5]);
      chk("R7 overflow", ovf_o, (i == 5) ? exp_ovf : 0);
      idx_ready_i = 1'b1;
      @(negedge clk_i);
      idx_ready_i = 1'b0;
    end
    chk("R6 idle after last", start_ready_o, 1);
  endtask

  function automatic logic [47:0] rnd_mods();
    logic [47:0] m;
    for (int i = 0; i < 6; i++) m[8*i +: 8] = 8'(2 + ($urandom % 127));
    return m;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R8 reset start_ready", start_ready_o, 1);
    chk("R8 reset idx_valid", idx_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle idx_valid", idx_valid_o, 0);
    // known vectors
    run_frame(64'hFFFFFF, 24, {6{8'd16}}, 1'b0);
    run_frame(64'h154FDF4, 26, {8'd26, 8'd27, 8'd16, 8'd24, 8'd17, 8'd23}, 1'b0);
    // R1: bits above the length ignored
    run_frame(64'h3FF_FF15_4FDF4, 26, {8'd26, 8'd27, 8'd16, 8'd24, 8'd17, 8'd23}, 1'b1);
    // R7: heavy overflow with smallest moduli
    run_frame(64'h1FF_FFFF_FFFF, 41, {6{8'd2}}, 1'b1);
    // largest moduli, max value
    run_frame(64'h1FF_FFFF_FFFF, 41, {6{8'd128}}, 1'b1);
    // R7 boundary: R5 exactly M5 then M5-1
    run_frame(64'd100 * 64'd32, 19, {8'd100, {5{8'd2}}}, 1'b0);
    run_frame(64'd99 * 64'd32, 19, {8'd100, {5{8'd2}}}, 1'b0);
    // R1 minimum length
    run_frame(64'hFFFF_FFFF, 19, rnd_mods(), 1'b1);
    for (int n = 0; n < 40; n++) begin
      longint unsigned d = {32'($urandom), 32'($urandom)};
      run_frame(d, 19 + int'($urandom % 23), rnd_mods(), 1'b1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule